// File: doc/BRIEF.md
# Relation-Flag Compare and Condition Unit

This block compares two 32-bit operands and records the outcome in a condition register in which each relation has a bit of its own. A compare does not store a carry, overflow or sign. It stores equality, inequality, four signed orderings and four unsigned orderings as ten independent bits. Several of these bits can be set at the same time. Either operand can come from a register value or from an immediate field, and both can be immediates.

A separate evaluator answers one question for the execute stage: does the requested condition hold? The answer drives both conditional branches and conditional moves, which share the same condition codes. The evaluator picks one flag bit with a one-hot mask and ANDs it with the stored register. An "always" code makes the answer independent of the flags. The evaluator reads the stored register, so a test issued in the same cycle as a compare sees the flags from before that compare.

Top module: `relcmp_cond_unit`

## Requirements
- R1: After reset, `ccFlags` is all zeros. While `testEn` is low, `take` is 0.
- R2: After a compare, bit 0 (not-equal) is 1 when the operands differ in any bit, and bit 1 (equal) is 1 when they are identical.
- R3: After a compare, the two's-complement signed relations are stored as follows: bit 2 is lhs >= rhs, bit 3 is lhs > rhs, bit 4 is lhs <= rhs and bit 5 is lhs < rhs.
- R4: After a compare, the unsigned relations are stored as follows: bit 6 is lhs >= rhs, bit 7 is lhs > rhs, bit 8 is lhs <= rhs and bit 9 is lhs < rhs.
- R5: Each side takes its immediate input when its `*IsImm` select is 1 and its register input otherwise. All four combinations of the two selects are allowed.
- R6: Bits 31 down to 10 of `ccFlags` always read as zero.
- R7: `ccFlags` is loaded only on a clock edge where `cmpEn` is 1. At every other edge it keeps its value, whatever the operand inputs do.
- R8: When `testEn` is 1 and `condSel` is in the range 0 to 9, `take` equals bit `condSel` of `ccFlags`.
- R9: When `testEn` is 1 and `condSel` is 15 (always), `take` is 1 for any flag value.
- R10: When `condSel` is between 10 and 14 (reserved), `take` is 0.
- R11: When a compare and a test occur in the same cycle, `take` uses the register value from before that compare. The new flags become visible from the next cycle.
- R12: While `testEn` is 0, `take` is 0 for every `condSel` and every flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmpEn | input | 1 | Loads the condition register at this edge |
| lhsIsImm | input | 1 | Left operand source: 1 selects the immediate |
| lhsReg | input | 32 | Left operand register value |
| lhsImm | input | 32 | Left operand immediate |
| rhsIsImm | input | 1 | Right operand source: 1 selects the immediate |
| rhsReg | input | 32 | Right operand register value |
| rhsImm | input | 32 | Right operand immediate |
| testEn | input | 1 | A conditional branch or move requests evaluation |
| condSel | input | 4 | Condition code: 0 to 9 select a flag bit, 15 means always, 10 to 14 are never taken |
| ccFlags | output | 32 | Condition register; bits 9 to 0 hold the relations |
| take | output | 1 | The branch is taken or the move commits |

## Verification
A corrupted flag bit shows up on `ccFlags` in the first cycle after the faulty compare. It reaches `take` as soon as a test selects that bit. A register that reloads when it should hold, or that latches the wrong operand source, shows up one cycle later as a flag word that no longer matches the last intended compare. The evaluator has no state, so a decode fault appears on `take` in the same cycle as the test. The same-cycle case checks `take` before and after the capturing edge.

// File: rtl/relcmp_pkg.sv
package relcmp_pkg;

  localparam int NUM_FLAGS = 10;
  localparam int SEL_W     = 4;

  // Flag positions; the condition code selecting a flag equals its index.
  localparam int FLAG_NE = 0;
  localparam int FLAG_EQ = 1;
  localparam int FLAG_GE = 2;
  localparam int FLAG_GT = 3;
  localparam int FLAG_LE = 4;
  localparam int FLAG_LT = 5;
  localparam int FLAG_HS = 6;
  localparam int FLAG_HI = 7;
  localparam int FLAG_LS = 8;
  localparam int FLAG_LO = 9;

  localparam logic [SEL_W-1:0] COND_ALWAYS = 4'd15;

  typedef struct packed {
    logic                 loadCc;
    logic                 testValid;
    logic                 alwaysTake;
    logic [NUM_FLAGS-1:0] flagMask;
  } ctrl_strobe_t;

endpackage

// File: rtl/relcmp_compare.sv
module relcmp_compare
  import relcmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  output logic [NUM_FLAGS-1:0] relFlags
);

  logic isEq;
  logic sLess;
  logic uLess;

  always_comb begin
    isEq  = (opA == opB);
    uLess = (opA < opB);
    sLess = ($signed(opA) < $signed(opB));

    relFlags          = '0;
    relFlags[FLAG_NE] = !isEq;
    relFlags[FLAG_EQ] = isEq;
    relFlags[FLAG_GE] = !sLess;
    relFlags[FLAG_GT] = !sLess && !isEq;
    relFlags[FLAG_LE] = sLess || isEq;
    relFlags[FLAG_LT] = sLess;
    relFlags[FLAG_HS] = !uLess;
    relFlags[FLAG_HI] = !uLess && !isEq;
    relFlags[FLAG_LS] = uLess || isEq;
    relFlags[FLAG_LO] = uLess;
  end

endmodule

// File: rtl/relcmp_ctrl.sv
module relcmp_ctrl
  import relcmp_pkg::*;
(
  input  logic             cmpEn,
  input  logic             testEn,
  input  logic [SEL_W-1:0] condSel,
  output ctrl_strobe_t     strobe
);

  logic [NUM_FLAGS-1:0] maskDec;

  // One-hot decode of the condition code to a flag mask.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_mask
    assign maskDec[i] = (condSel == SEL_W'(i));
  end

  always_comb begin
    strobe.loadCc     = cmpEn;
    strobe.testValid  = testEn;
    strobe.alwaysTake = (condSel == COND_ALWAYS);
    strobe.flagMask   = maskDec;
  end

endmodule

// File: rtl/relcmp_datapath.sv
module relcmp_datapath
  import relcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  logic              lhsIsImm,
  input  logic [DATA_W-1:0] lhsReg,
  input  logic [DATA_W-1:0] lhsImm,
  input  logic              rhsIsImm,
  input  logic [DATA_W-1:0] rhsReg,
  input  logic [DATA_W-1:0] rhsImm,
  output logic [CC_W-1:0]   ccFlags,
  output logic              take
);

  localparam int PAD_W = CC_W - NUM_FLAGS;

  logic [DATA_W-1:0]    opA;
  logic [DATA_W-1:0]    opB;
  logic [NUM_FLAGS-1:0] relNext;
  logic [NUM_FLAGS-1:0] ccReg;

  assign opA = lhsIsImm ? lhsImm : lhsReg;
  assign opB = rhsIsImm ? rhsImm : rhsReg;

  relcmp_compare #(.DATA_W(DATA_W)) cmp_i (
    .opA      (opA),
    .opB      (opB),
    .relFlags (relNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ccReg <= '0;
    else if (strobe.loadCc) ccReg <= relNext;
  end

  assign ccFlags = {{PAD_W{1'b0}}, ccReg};

  // Evaluation reads the stored register only.
  assign take = strobe.testValid &&
                (strobe.alwaysTake || (|(ccReg & strobe.flagMask)));

endmodule

// File: rtl/relcmp_cond_unit.sv
module relcmp_cond_unit
  import relcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpEn,
  input  logic              lhsIsImm,
  input  logic [DATA_W-1:0] lhsReg,
  input  logic [DATA_W-1:0] lhsImm,
  input  logic              rhsIsImm,
  input  logic [DATA_W-1:0] rhsReg,
  input  logic [DATA_W-1:0] rhsImm,
  input  logic              testEn,
  input  logic [SEL_W-1:0]  condSel,
  output logic [CC_W-1:0]   ccFlags,
  output logic              take
);

  ctrl_strobe_t strobe;

  relcmp_ctrl ctrl_i (
    .cmpEn   (cmpEn),
    .testEn  (testEn),
    .condSel (condSel),
    .strobe  (strobe)
  );

  relcmp_datapath #(.DATA_W(DATA_W), .CC_W(CC_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .lhsIsImm (lhsIsImm),
    .lhsReg   (lhsReg),
    .lhsImm   (lhsImm),
    .rhsIsImm (rhsIsImm),
    .rhsReg   (rhsReg),
    .rhsImm   (rhsImm),
    .ccFlags  (ccFlags),
    .take     (take)
  );

endmodule

// File: rtl/relcmp_checker.sv
module relcmp_checker
  import relcmp_pkg::*;
#(
  parameter int CC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmpEn,
  input logic             testEn,
  input logic [SEL_W-1:0] condSel,
  input logic [CC_W-1:0]  ccFlags,
  input logic             take
);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ccFlags[CC_W-1:NUM_FLAGS] == '0); // R6

  AST_HOLD_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpEn |=> $stable(ccFlags)); // R7

  AST_EQ_NE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    cmpEn |=> (ccFlags[FLAG_EQ] != ccFlags[FLAG_NE])); // R2

  AST_SIGNED_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    cmpEn |=> ((ccFlags[FLAG_GE] != ccFlags[FLAG_LT]) &&
               (ccFlags[FLAG_LE] != ccFlags[FLAG_GT]))); // R3

  AST_UNSIGNED_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    cmpEn |=> ((ccFlags[FLAG_HS] != ccFlags[FLAG_LO]) &&
               (ccFlags[FLAG_LS] != ccFlags[FLAG_HI]))); // R4

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !testEn |-> !take); // R12

  AST_ALWAYS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (testEn && condSel == COND_ALWAYS) |-> take); // R9

  AST_RESERVED_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (condSel >= 4'd10 && condSel <= 4'd14) |-> !take); // R10

endmodule

bind relcmp_cond_unit relcmp_checker #(.CC_W(CC_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmpEn   (cmpEn),
  .testEn  (testEn),
  .condSel (condSel),
  .ccFlags (ccFlags),
  .take    (take)
);

// File: tb/relcmp_cond_unit_tb_top.sv
module relcmp_cond_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmpEn = 1'b0;
  logic        lhsIsImm = 1'b0;
  logic [31:0] lhsReg = '0;
  logic [31:0] lhsImm = '0;
  logic        rhsIsImm = 1'b0;
  logic [31:0] rhsReg = '0;
  logic [31:0] rhsImm = '0;
  logic        testEn = 1'b0;
  logic [3:0]  condSel = '0;
  logic [31:0] ccFlags;
  logic        take;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  relcmp_cond_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmpEn(cmpEn),
    .lhsIsImm(lhsIsImm), .lhsReg(lhsReg), .lhsImm(lhsImm),
    .rhsIsImm(rhsIsImm), .rhsReg(rhsReg), .rhsImm(rhsImm),
    .testEn(testEn), .condSel(condSel), .ccFlags(ccFlags), .take(take)
  );

  function automatic logic [31:0] expFlags(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] f = '0;
    f[0] = (a != b);
    f[1] = (a == b);
    f[2] = ($signed(a) >= $signed(b));
    f[3] = ($signed(a) >  $signed(b));
    f[4] = ($signed(a) <= $signed(b));
    f[5] = ($signed(a) <  $signed(b));
    f[6] = (a >= b);
    f[7] = (a >  b);
    f[8] = (a <= b);
    f[9] = (a <  b);
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Compare a against b with chosen sources; the unused source carries junk.
  task automatic doCompare(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic aImm, input logic bImm);
    @(negedge clk);
    cmpEn = 1'b1;
    lhsIsImm = aImm; rhsIsImm = bImm;
    lhsImm = aImm ? a : ~a;  lhsReg = aImm ? ~a : a;
    rhsImm = bImm ? b : (b ^ 32'h5A5A_0001);
    rhsReg = bImm ? (b ^ 32'h5A5A_0001) : b;
    @(posedge clk); #2;
    cmpEn = 1'b0;
    check(req, ccFlags, expFlags(a, b));
  endtask

  task automatic testReset();
    check("R1 reset flags", ccFlags, 32'h0);
    check("R1 reset take", {31'h0, take}, 32'h0);
  endtask

  task automatic testRelations();
    doCompare("R2 R3 R4 equal", 32'd7, 32'd7, 1'b0, 1'b0);
    doCompare("R3 R4 neg vs pos", 32'h8000_0000, 32'd1, 1'b0, 1'b0);
    doCompare("R3 R4 pos vs neg", 32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    doCompare("R2 R3 R4 small vs big", 32'd3, 32'd100, 1'b0, 1'b0);
    doCompare("R2 single bit diff", 32'h0001_0000, 32'h0000_0000, 1'b0, 1'b0);
  endtask

  task automatic testSources();
    doCompare("R5 reg-imm", 32'h1234, 32'h1235, 1'b0, 1'b1);
    doCompare("R5 imm-reg", 32'hFFFF_0000, 32'h10, 1'b1, 1'b0);
    doCompare("R5 imm-imm", 32'h42, 32'h42, 1'b1, 1'b1);
  endtask

  task automatic testHold();
    logic [31:0] exp = expFlags(32'd5, 32'd9);
    doCompare("R7 setup", 32'd5, 32'd9, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lhsReg = 32'd100 + k; rhsReg = 32'd3; lhsIsImm = k[0]; lhsImm = k;
      @(posedge clk); #2;
      check("R7 hold without compare", ccFlags, exp);
      check("R6 upper zero", {22'h0, ccFlags[31:10] != 0}, 32'h0);
    end
  endtask

  task automatic testSelect();
    logic [31:0] f = expFlags(32'h8000_0000, 32'd1);
    doCompare("R8 setup", 32'h8000_0000, 32'd1, 1'b0, 1'b0);
    for (int s = 0; s < 10; s++) begin
      @(negedge clk);
      testEn = 1'b1; condSel = s[3:0];
      #2;
      check($sformatf("R8 cond %0d", s), {31'h0, take}, {31'h0, f[s]});
    end
    for (int s = 10; s < 15; s++) begin
      @(negedge clk);
      condSel = s[3:0];
      #2;
      check($sformatf("R10 reserved %0d", s), {31'h0, take}, 32'h0);
    end
    @(negedge clk); testEn = 1'b0;
  endtask

  task automatic testAlways();
    doCompare("R9 setup", 32'd1, 32'd2, 1'b0, 1'b0);
    @(negedge clk);
    testEn = 1'b1; condSel = 4'd15; #2;
    check("R9 always", {31'h0, take}, 32'h1);
    testEn = 1'b0; #2;
    check("R12 idle always", {31'h0, take}, 32'h0);
    condSel = 4'd0; #2;
    check("R12 idle flag set", {31'h0, take}, 32'h0);
  endtask

  task automatic testSameCycle();
    doCompare("R11 setup", 32'd4, 32'd8, 1'b0, 1'b0);
    @(negedge clk);
    cmpEn = 1'b1; lhsIsImm = 1'b0; rhsIsImm = 1'b0;
    lhsReg = 32'd6; rhsReg = 32'd6;
    testEn = 1'b1; condSel = 4'd1;
    #2;
    check("R11 old value used", {31'h0, take}, 32'h0);
    @(posedge clk); #2;
    cmpEn = 1'b0;
    check("R11 new flags", ccFlags, expFlags(32'd6, 32'd6));
    check("R11 new take", {31'h0, take}, 32'h1);
    testEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    testReset();
    @(negedge clk); rst_n = 1'b1;
    testRelations();
    testSources();
    testHold();
    testSelect();
    testAlways();
    testSameCycle();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule